// File: doc/BRIEF.md
# Video Input Formatter with Active Window

This block sits behind the deserialized video input of a panel timing controller. Each pixel clock it takes one 24-bit RGB sample, together with HSYNC and VSYNC. The RGB sample carries 8 bits per colour. The block reduces each colour to 6 bits. In 6-bit mode it uses the upper six bits of each colour byte. In 8-bit mode it either drops the two low bits or spreads them over four frames as a dither pattern.

The block finds the active window from the sync falling edges. A programmable count of pixel clocks after the HSYNC falling edge marks the first active pixel. A programmable count of HSYNC pulses after the VSYNC falling edge marks the first active line. On lines past the panel's last active line, the block can replace the data with all zeros or all ones while the GPO9 input is low.

All outputs are registered. They appear on the clock edge after the input sample they belong to.

Top module: `vin_formatter`

## Requirements
- R1: While reset is high, and on the first edge after it, `de_out` is 0 and `rgb_out`, `pix_out` and `line_out` are all zero.
- R2: A sample counts as an HSYNC falling edge when `hsync` is low and the previous sample was high. Let that sample be position 0. The active pixels are the samples at positions `cfg_hbp` through `cfg_hbp+WIDTH-1`, where WIDTH is 1024 by default. `pix_out` numbers these pixels from 0. Each sample's result appears one clock later.
- R3: After a VSYNC falling edge, the block counts later HSYNC falling edges as lines 1, 2, 3 and so on. Lines up to `cfg_vbp` never raise `de_out`. Line `cfg_vbp+k` reports `line_out = k`. An HSYNC falling edge in the same sample as a VSYNC falling edge is not counted.
- R4: The input places red, green and blue in bits [23:16], [15:8] and [7:0]. The output places them in [17:12], [11:6] and [5:0]. With `cfg_8bit = 0`, each output colour is bits [7:2] of its byte. The low two bits are ignored and `cfg_frc_off` has no effect.
- R5: With `cfg_8bit = 1` and `cfg_frc_off = 1`, each colour is truncated to bits [7:2].
- R6: With `cfg_8bit = 1` and `cfg_frc_off = 0`, each colour is computed as follows. Start from bits [7:2]. Add 1 when the low two bits exceed idx, where idx = (frame + 2*line_out[0] + pix_out[0]) mod 4. The sum saturates at 63.
- R7: The 2-bit frame number is 0 after reset. It advances by one, modulo 4, on each VSYNC falling edge.
- R8: Consider an active pixel on a line whose `line_out` exceeds LINES (768 by default), sampled while `gpo9` is 0. If `cfg_fill` is 2'b10, the output is all zeros. If `cfg_fill` is 2'b11, the output is all ones. With `gpo9` high, with `cfg_fill` of 2'b00 or 2'b01, or on lines up to LINES, the data passes unchanged.
- R9: Whenever `de_out` is 0, `rgb_out`, `pix_out` and `line_out` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| hsync | input | 1 | Horizontal sync; the falling edge starts a line |
| vsync | input | 1 | Vertical sync; the falling edge starts a frame |
| rgb_in | input | 24 | Input pixel, 8 bits per colour |
| gpo9 | input | 1 | State of the row-control output that gates fill |
| cfg_8bit | input | 1 | 1: 8-bit video, 0: 6-bit video |
| cfg_frc_off | input | 1 | In 8-bit mode, 1 truncates and 0 dithers |
| cfg_fill | input | 2 | Fill selection for lines beyond the active region |
| cfg_hbp | input | HBP_W (11) | Horizontal back porch, in pixel clocks |
| cfg_vbp | input | VBP_W (11) | Vertical back porch, in HSYNC pulses |
| rgb_out | output | 18 | Output pixel, 6 bits per colour |
| de_out | output | 1 | Data valid |
| pix_out | output | $clog2(WIDTH) | Active pixel index |
| line_out | output | VCNT_W | Active line number, starting at 1 |

## Verification
The hardest case to reach from the ports is the fill path. It needs a line numbered past LINES, and with the default geometry that takes close to a million clocks. The bench therefore shrinks WIDTH and LINES and sends frames with more lines than LINES. It draws `gpo9` per line and `cfg_fill` per frame at random, so every combination of gate and fill code falls on lines past the boundary. The dither index depends on the frame number, which is only visible through the data. Many consecutive frames with random pixels and all-ones pixels therefore cover every frame phase and the saturation case. One directed frame makes the two sync falling edges coincide.

// File: rtl/vin_pkg.sv
package vin_pkg;

    typedef enum logic [1:0] {
        FILL_NONE  = 2'b00,
        FILL_RSVD  = 2'b01,
        FILL_BLACK = 2'b10,
        FILL_WHITE = 2'b11
    } fill_e;

    typedef struct packed {
        logic [7:0] r;
        logic [7:0] g;
        logic [7:0] b;
    } rgb8_t;

    typedef struct packed {
        logic [5:0] r;
        logic [5:0] g;
        logic [5:0] b;
    } rgb6_t;

    localparam int CHANNELS = 3;

    // Dither threshold position for one pixel of one frame.
    function automatic logic [1:0] dither_index(input logic [1:0] frame,
                                                input logic       line_par,
                                                input logic       pix_par);
        return frame + {line_par, pix_par};
    endfunction

    // Reduce an 8-bit colour to 6 bits, carrying the dropped bits as a
    // temporal increment; clamps at full scale.
    function automatic logic [5:0] dither_chan(input logic [7:0] v,
                                               input logic [1:0] idx);
        logic [5:0] hi;
        hi = v[7:2];
        if ((v[1:0] > idx) && (hi != 6'h3F)) begin
            return hi + 6'd1;
        end
        return hi;
    endfunction

endpackage

// File: rtl/vin_window.sv
module vin_window #(
    parameter int WIDTH  = 1024,
    parameter int HBP_W  = 11,
    parameter int VBP_W  = 11,
    parameter int HCNT_W = 12,
    parameter int VCNT_W = 13,
    parameter int PIX_W  = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hsync,
    input  logic              vsync,
    input  logic [HBP_W-1:0]  cfg_hbp,
    input  logic [VBP_W-1:0]  cfg_vbp,
    output logic              win_de,
    output logic [PIX_W-1:0]  win_pix,
    output logic [VCNT_W-1:0] win_line,
    output logic [1:0]        win_frame
);

    logic              hs_q, vs_q;
    logic              hs_fall, vs_fall;
    logic              h_run, v_run;
    logic [HCNT_W-1:0] h_cnt;
    logic [VCNT_W-1:0] v_cnt;
    logic [1:0]        frame;

    logic [HCNT_W:0]   pos_x, hbp_x, off_x;
    logic              h_act;
    logic [VCNT_W-1:0] n_now, vbp_x;

    assign hs_fall = hs_q & ~hsync;
    assign vs_fall = vs_q & ~vsync;

    always_ff @(posedge clk) begin
        if (rst) begin
            hs_q  <= 1'b1;
            vs_q  <= 1'b1;
            h_run <= 1'b0;
            h_cnt <= '0;
            v_run <= 1'b0;
            v_cnt <= '0;
            frame <= 2'd0;
        end else begin
            hs_q <= hsync;
            vs_q <= vsync;
            if (hs_fall) begin
                h_run <= 1'b1;
                h_cnt <= HCNT_W'(1);
            end else if (h_run && (h_cnt != '1)) begin
                h_cnt <= h_cnt + 1'b1;
            end
            if (vs_fall) begin
                v_run <= 1'b1;
                v_cnt <= '0;
                frame <= frame + 2'd1;
            end else if (v_run && hs_fall && (v_cnt != '1)) begin
                v_cnt <= v_cnt + 1'b1;
            end
        end
    end

    always_comb begin
        pos_x = {1'b0, (hs_fall ? {HCNT_W{1'b0}} : h_cnt)};
        hbp_x = (HCNT_W+1)'(cfg_hbp);
        off_x = pos_x - hbp_x;
        h_act = (hs_fall || h_run) && (pos_x >= hbp_x) &&
                (pos_x < hbp_x + (HCNT_W+1)'(WIDTH));

        if (vs_fall)                       n_now = '0;
        else if (hs_fall && (v_cnt != '1)) n_now = v_cnt + 1'b1;
        else                               n_now = v_cnt;
        vbp_x    = VCNT_W'(cfg_vbp);
        win_line = (v_run && (n_now > vbp_x)) ? (n_now - vbp_x) : '0;
    end

    assign win_de    = h_act && (win_line != '0);
    assign win_pix   = h_act ? PIX_W'(off_x) : '0;
    assign win_frame = frame;

    a_r7_frame_step: assert property (@(posedge clk) disable iff (rst)
        vs_fall |=> (frame == $past(frame) + 2'd1));

    a_r3_line_hold: assert property (@(posedge clk) disable iff (rst)
        (v_run && !hs_fall && !vs_fall) |=> (v_cnt == $past(v_cnt)));

    a_r2_restart: assert property (@(posedge clk) disable iff (rst)
        hs_fall |=> (h_run && (h_cnt == HCNT_W'(1))));

endmodule

// File: rtl/vin_depth.sv
module vin_depth
    import vin_pkg::*;
(
    input  logic [23:0] pix_in,
    input  logic        mode_8bit,
    input  logic        frc_off,
    input  logic [1:0]  frame,
    input  logic        line_par,
    input  logic        pix_par,
    output logic [17:0] pix_out
);

    logic [1:0] idx;
    logic       use_dither;

    assign idx        = dither_index(frame, line_par, pix_par);
    assign use_dither = mode_8bit && !frc_off;

    for (genvar c = 0; c < CHANNELS; c++) begin : g_chan
        assign pix_out[6*c +: 6] = use_dither
                                 ? dither_chan(pix_in[8*c +: 8], idx)
                                 : pix_in[8*c+2 +: 6];
    end

endmodule

// File: rtl/vin_formatter.sv
module vin_formatter
    import vin_pkg::*;
#(
    parameter int WIDTH = 1024,
    parameter int LINES = 768,
    parameter int HBP_W = 11,
    parameter int VBP_W = 11,
    localparam int PIX_W  = $clog2(WIDTH),
    localparam int HCNT_W = $clog2((2**HBP_W) + WIDTH),
    localparam int VCNT_W = $clog2((2**VBP_W) + 2*LINES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hsync,
    input  logic              vsync,
    input  logic [23:0]       rgb_in,
    input  logic              gpo9,
    input  logic              cfg_8bit,
    input  logic              cfg_frc_off,
    input  logic [1:0]        cfg_fill,
    input  logic [HBP_W-1:0]  cfg_hbp,
    input  logic [VBP_W-1:0]  cfg_vbp,
    output logic [17:0]       rgb_out,
    output logic              de_out,
    output logic [PIX_W-1:0]  pix_out,
    output logic [VCNT_W-1:0] line_out
);

    logic              win_de;
    logic [PIX_W-1:0]  win_pix;
    logic [VCNT_W-1:0] win_line;
    logic [1:0]        win_frame;
    logic [17:0]       depth_rgb;
    logic [17:0]       next_rgb;
    logic              beyond, fill_hit;
    fill_e             fill_mode;

    vin_window #(
        .WIDTH (WIDTH),
        .HBP_W (HBP_W),
        .VBP_W (VBP_W),
        .HCNT_W(HCNT_W),
        .VCNT_W(VCNT_W),
        .PIX_W (PIX_W)
    ) u_window (
        .clk      (clk),
        .rst      (rst),
        .hsync    (hsync),
        .vsync    (vsync),
        .cfg_hbp  (cfg_hbp),
        .cfg_vbp  (cfg_vbp),
        .win_de   (win_de),
        .win_pix  (win_pix),
        .win_line (win_line),
        .win_frame(win_frame)
    );

    vin_depth u_depth (
        .pix_in   (rgb_in),
        .mode_8bit(cfg_8bit),
        .frc_off  (cfg_frc_off),
        .frame    (win_frame),
        .line_par (win_line[0]),
        .pix_par  (win_pix[0]),
        .pix_out  (depth_rgb)
    );

    assign fill_mode = fill_e'(cfg_fill);
    assign beyond    = win_line > VCNT_W'(LINES);
    assign fill_hit  = beyond && !gpo9 &&
                       ((fill_mode == FILL_BLACK) || (fill_mode == FILL_WHITE));

    always_comb begin
        if (fill_hit) next_rgb = (fill_mode == FILL_WHITE) ? '1 : '0;
        else          next_rgb = depth_rgb;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            de_out   <= 1'b0;
            rgb_out  <= '0;
            pix_out  <= '0;
            line_out <= '0;
        end else begin
            de_out   <= win_de;
            rgb_out  <= win_de ? next_rgb : '0;
            pix_out  <= win_de ? win_pix  : '0;
            line_out <= win_de ? win_line : '0;
        end
    end

    a_r9_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !de_out |-> ((rgb_out == '0) && (pix_out == '0) && (line_out == '0)));

    a_r3_line_nonzero: assert property (@(posedge clk) disable iff (rst)
        de_out |-> (line_out != '0));

    a_r2_pix_step: assert property (@(posedge clk) disable iff (rst)
        (de_out && $past(de_out) && (line_out == $past(line_out)))
        |-> (pix_out == PIX_W'($past(pix_out) + 1'b1)));

    a_r8_black_fill: assert property (@(posedge clk) disable iff (rst)
        (win_de && beyond && !gpo9 && (cfg_fill == 2'b10)) |=> (rgb_out == '0));

    a_r6_saturate: assert property (@(posedge clk) disable iff (rst)
        (win_de && !fill_hit && cfg_8bit && !cfg_frc_off && (rgb_in[23:18] == 6'h3F))
        |=> (rgb_out[17:12] == 6'h3F));

endmodule

// File: tb/vin_formatter_bench.sv
module vin_formatter_bench;

    localparam int W    = 16;
    localparam int LN   = 6;
    localparam int HBW  = 4;
    localparam int VBW  = 3;
    localparam int PW   = $clog2(W);
    localparam int HCW  = $clog2((2**HBW) + W);
    localparam int VW   = $clog2((2**VBW) + 2*LN);
    localparam int HMAX = (2**HCW) - 1;
    localparam int VMAX = (2**VW) - 1;

    logic           clk = 1'b0;
    logic           rst;
    logic           hsync, vsync, gpo9;
    logic [23:0]    rgb_in;
    logic           cfg_8bit, cfg_frc_off;
    logic [1:0]     cfg_fill;
    logic [HBW-1:0] cfg_hbp;
    logic [VBW-1:0] cfg_vbp;
    logic [17:0]    rgb_out;
    logic           de_out;
    logic [PW-1:0]  pix_out;
    logic [VW-1:0]  line_out;

    int n_cmp = 0;
    int n_bad = 0;

    // bench model state
    bit m_hs_prev, m_vs_prev, m_hrun, m_vrun;
    int m_hcnt, m_vcnt, m_frame;

    always #5 clk = ~clk;

    vin_formatter #(
        .WIDTH(W), .LINES(LN), .HBP_W(HBW), .VBP_W(VBW)
    ) u_vin_formatter (
        .clk(clk), .rst(rst), .hsync(hsync), .vsync(vsync),
        .rgb_in(rgb_in), .gpo9(gpo9), .cfg_8bit(cfg_8bit),
        .cfg_frc_off(cfg_frc_off), .cfg_fill(cfg_fill),
        .cfg_hbp(cfg_hbp), .cfg_vbp(cfg_vbp), .rgb_out(rgb_out),
        .de_out(de_out), .pix_out(pix_out), .line_out(line_out)
    );

    task automatic check(input string tag, input string what, input int got, input int exp);
        n_cmp++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s %s got %0h exp %0h at %0t", tag, what, got, exp, $time);
        end
    endtask

    function automatic logic [17:0] expect_rgb(input logic [23:0] px, input logic g,
                                               input int lnum, input int pix, input int frame);
        logic [17:0] r;
        for (int c = 0; c < 3; c++) begin
            int v, o, idx;
            v = int'(px[8*c +: 8]);
            o = v / 4;
            if (cfg_8bit && !cfg_frc_off) begin
                idx = (frame + 2*(lnum % 2) + (pix % 2)) % 4;
                if (((v % 4) > idx) && (o < 63)) o = o + 1;
            end
            r[6*c +: 6] = 6'(o);
        end
        if ((lnum > LN) && !g && cfg_fill[1]) r = cfg_fill[0] ? 18'h3FFFF : 18'h0;
        return r;
    endfunction

    task automatic step(input logic hs, input logic vs, input logic [23:0] px, input logic g);
        bit hf, vf, hact, de;
        int pos, n, lnum, pix;
        logic [17:0] exp_rgb;
        string tag;
        @(negedge clk);
        hsync = hs; vsync = vs; rgb_in = px; gpo9 = g;
        hf   = m_hs_prev && !hs;
        vf   = m_vs_prev && !vs;
        pos  = hf ? 0 : m_hcnt;
        hact = (hf || m_hrun) && (pos >= int'(cfg_hbp)) && (pos < int'(cfg_hbp) + W);
        if (vf)      n = 0;
        else if (hf) n = (m_vcnt < VMAX) ? m_vcnt + 1 : m_vcnt;
        else         n = m_vcnt;
        lnum = (m_vrun && (n > int'(cfg_vbp))) ? n - int'(cfg_vbp) : 0;
        de   = hact && (lnum != 0);
        pix  = de ? pos - int'(cfg_hbp) : 0;
        exp_rgb = de ? expect_rgb(px, g, lnum, pix, m_frame) : 18'h0;
        if (!de)                                        tag = "R9";
        else if ((lnum > LN) && !g && cfg_fill[1])     tag = "R8";
        else if (!cfg_8bit)                             tag = "R4";
        else if (cfg_frc_off)                           tag = "R5";
        else                                            tag = "R6 R7";
        // advance model
        m_hs_prev = hs;
        m_vs_prev = vs;
        if (hf) begin m_hrun = 1; m_hcnt = 1; end
        else if (m_hrun && (m_hcnt < HMAX)) m_hcnt++;
        if (vf) begin m_vrun = 1; m_vcnt = 0; m_frame = (m_frame + 1) % 4; end
        else if (m_vrun && hf && (m_vcnt < VMAX)) m_vcnt++;
        @(posedge clk); #1;
        check("R2", "de", int'(de_out), int'(de));
        check("R2", "pix", int'(pix_out), pix);
        check("R3", "line", int'(line_out), de ? lnum : 0);
        check(tag, "rgb", int'(rgb_out), int'(exp_rgb));
    endtask

    task automatic frame(input int nlines, input bit coincide, input int pmode);
        if (!coincide) begin
            step(1'b1, 1'b0, 24'h0, 1'b0);
            step(1'b1, 1'b0, 24'h0, 1'b0);
            step(1'b1, 1'b1, 24'h0, 1'b0);
        end
        for (int l = 0; l < nlines; l++) begin
            logic g;
            int len;
            g   = (($urandom % 3) == 0);
            len = int'(cfg_hbp) + W + 4;
            for (int s = 0; s < len; s++) begin
                logic hs, vs;
                logic [23:0] px;
                hs = (s < 2) ? 1'b0 : 1'b1;
                vs = (coincide && (l == 0) && (s < 2)) ? 1'b0 : 1'b1;
                px = (pmode == 1) ? 24'hFFFFFF : 24'($urandom);
                step(hs, vs, px, g);
            end
        end
    endtask

    task automatic set_cfg(input logic b8, input logic fo, input logic [1:0] fl,
                           input int hbp, input int vbp);
        @(negedge clk);
        cfg_8bit = b8; cfg_frc_off = fo; cfg_fill = fl;
        cfg_hbp = HBW'(hbp); cfg_vbp = VBW'(vbp);
    endtask

    initial begin
        #(10 * 150000);
        n_bad++;
        $display("FAIL watchdog R1 got running exp finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        rst = 1'b1; hsync = 1'b1; vsync = 1'b1; gpo9 = 1'b1; rgb_in = 24'h0;
        cfg_8bit = 1'b0; cfg_frc_off = 1'b0; cfg_fill = 2'b00;
        cfg_hbp = '0; cfg_vbp = '0;
        m_hs_prev = 1; m_vs_prev = 1; m_hrun = 0; m_vrun = 0;
        m_hcnt = 0; m_vcnt = 0; m_frame = 0;
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        check("R1", "de", int'(de_out), 0);
        check("R1", "rgb", int'(rgb_out), 0);
        check("R1", "pix", int'(pix_out), 0);
        check("R1", "line", int'(line_out), 0);
        @(negedge clk);
        rst = 1'b0;

        // directed: 6-bit mode, zero porches (R4, R2, R3)
        set_cfg(1'b0, 1'b0, 2'b00, 0, 0);
        frame(8, 1'b0, 0);
        // directed: truncation with black fill beyond line LN (R5, R8)
        set_cfg(1'b1, 1'b1, 2'b10, 3, 2);
        frame(11, 1'b0, 0);
        // directed: dither with all-ones pixels for saturation, white fill (R6, R8)
        set_cfg(1'b1, 1'b0, 2'b11, 5, 1);
        frame(9, 1'b0, 1);
        // directed: vsync and hsync falling together (R3)
        set_cfg(1'b1, 1'b0, 2'b01, 2, 1);
        frame(9, 1'b1, 0);

        // random frames cover every frame phase (R7) and mode mix
        for (int f = 0; f < 40; f++) begin
            set_cfg(1'($urandom % 2), 1'(($urandom % 3) == 0), 2'($urandom % 4),
                    int'($urandom % 6), int'($urandom % 4));
            frame(7 + int'($urandom % 5), 1'(($urandom % 8) == 0),
                  (($urandom % 5) == 0) ? 1 : 0);
        end
        repeat (4) step(1'b1, 1'b1, 24'h0, 1'b1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule